// File: doc/BRIEF.md
# Reset Source Aggregator with Cause Register

This block collects three internal reset requests: a watchdog underflow, an oscillator clock failure (main or sub oscillator), and a main-oscillator frequency-out-of-range event. It turns them into a single system reset pulse of fixed length. It also records which sources asked for the reset in a cause register. The generated reset does not clear that register. A small clock-supervisor status register sits beside it and records which oscillator failed.

The request inputs are asynchronous. Each one passes through a two-flop synchronizer and is taken on its rising edge, so a source that keeps its request high until the reset clears it triggers only one pulse. While a generated pulse is active, a preserve indication tells the retention domain (backup registers, retained-RAM control, wake-factor registers) to keep its state. Software reads both registers through a small read port. A read of the cause register with the read strobe clears it, so flags from several resets build up until software reads them. Only power-on reset clears both registers.

Top module: `rst_cause_agg`

## Requirements
- R1: A rising watchdog request starts a system reset pulse and sets cause bit 5.
- R2: A rising clock-failure request starts a pulse and sets cause bit 6. It also sets supervisor status bit 0 for a main-oscillator failure or bit 1 for a sub-oscillator failure.
- R3: A rising frequency-anomaly request starts a pulse and sets cause bit 7. All other cause bits stay 0.
- R4: `sys_rst` first reads high after the third rising clock edge that follows a request change: two synchronizer stages, then the pulse register. It then stays high for exactly RST_LEN (default 16) cycles.
- R5: Requests that rise together, or that rise while a pulse is active, all set their cause bits. A rise during a pulse does not lengthen it or start a new one.
- R6: A request held high gives only one pulse. A new pulse needs the request to fall and rise again.
- R7: With `rd_addr`=0, `rd_data` shows the cause register. With `rd_addr`=1, it shows the supervisor status, zero-extended. A clock edge with `rd_en`=1 and `rd_addr`=0 clears the cause register, but a cause bit set on that same edge is kept. Reading without `rd_en`, or reading address 1, clears nothing, and the supervisor status is never cleared by a read.
- R8: A generated pulse leaves the cause register and the supervisor status unchanged, so bits from successive resets accumulate. Only power-on reset (`por_n`=0) clears both registers.
- R9: `keep_dom` is high exactly while a generated pulse is active and low while `por_n`=0. `sys_rst` is also high while `por_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wdg_req | input | 1 | Watchdog underflow request, asynchronous |
| cf_main_req | input | 1 | Main oscillator failure request, asynchronous |
| cf_sub_req | input | 1 | Sub oscillator failure request, asynchronous |
| freq_req | input | 1 | Main oscillator frequency anomaly request, asynchronous |
| rd_en | input | 1 | Read strobe; clears the cause register when rd_addr is 0 |
| rd_addr | input | 1 | 0: cause register, 1: supervisor status |
| rd_data | output | CAUSE_W | Selected register contents |
| sys_rst | output | 1 | System reset, active high |
| keep_dom | output | 1 | Retention domain preserve indication |

## Verification
A wrong synchronizer depth or a wrong pulse counter shows at once on `sys_rst`. The pulse starts one cycle too early or too late, or ends at a count other than RST_LEN, and the bench measures both edges of the pulse to the cycle. A wrong cause or status bit, or one lost to a pulse that cleared it, shows on `rd_data` as soon as the register is read after the pulse. A wrong clear policy shows on the read that follows a strobed read, a read without the strobe, or a power-on reset. A rising-edge detector that does not work shows as a second pulse right after the first while the request is still held.

// File: rtl/rst_cause_agg.sv
module rst_cause_agg #(
  parameter int CAUSE_W = 16,
  parameter int RST_LEN = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               wdg_req,
  input  logic               cf_main_req,
  input  logic               cf_sub_req,
  input  logic               freq_req,
  input  logic               rd_en,
  input  logic               rd_addr,
  output logic [CAUSE_W-1:0] rd_data,
  output logic               sys_rst,
  output logic               keep_dom
);
  localparam int CW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(RST_LEN - 1);

  logic [3:0] sync1, sync2, prev;
  logic [3:0] evt;
  logic       active;
  logic [CW-1:0] cnt;
  logic [CAUSE_W-1:0] cause, cause_set;
  logic [1:0] sup;
  logic       rd_clr;

  assign evt = sync2 & ~prev;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= {freq_req, cf_sub_req, cf_main_req, wdg_req};
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (|evt) begin
        active <= 1'b1;
        cnt    <= CNT_TOP;
      end
    end else if (cnt == '0) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    cause_set    = '0;
    cause_set[5] = evt[0];
    cause_set[6] = evt[1] | evt[2];
    cause_set[7] = evt[3];
  end

  assign rd_clr = rd_en && !rd_addr;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause <= '0;
      sup   <= '0;
    end else begin
      cause <= (rd_clr ? '0 : cause) | cause_set;
      sup   <= sup | evt[2:1];
    end
  end

  assign rd_data  = rd_addr ? CAUSE_W'(sup) : cause;
  assign sys_rst  = active | ~por_n;
  assign keep_dom = active & por_n;

  p_wdg_bit_r1: assert property (@(posedge clk) disable iff (!por_n)
    evt[0] |=> cause[5]);
  p_main_fail_r2: assert property (@(posedge clk) disable iff (!por_n)
    evt[1] |=> (sup[0] && cause[6]));
  p_sub_fail_r2: assert property (@(posedge clk) disable iff (!por_n)
    evt[2] |=> (sup[1] && cause[6]));
  p_freq_bit_r3: assert property (@(posedge clk) disable iff (!por_n)
    evt[3] |=> cause[7]);
  p_no_extend_r5: assert property (@(posedge clk) disable iff (!por_n)
    (active && cnt != '0) |=> (active && cnt == $past(cnt) - 1'b1));
  p_sup_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    sup[0] |=> sup[0]);
  p_keep_match_r9: assert property (@(posedge clk) disable iff (!por_n)
    keep_dom == sys_rst);
  always_comb begin
    if (!por_n) p_keep_low_por_r9: assert (!keep_dom && sys_rst);
  end
endmodule

// File: tb/rst_cause_agg_tb.sv
module rst_cause_agg_tb_top;
  localparam int CW = 16;
  localparam int LEN = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic wdg_req = 0, cf_main_req = 0, cf_sub_req = 0, freq_req = 0;
  logic rd_en = 0, rd_addr = 0;
  logic [CW-1:0] rd_data;
  logic sys_rst, keep_dom;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  rst_cause_agg #(.CAUSE_W(CW), .RST_LEN(LEN)) dut_i (
    .clk(clk), .por_n(por_n), .wdg_req(wdg_req), .cf_main_req(cf_main_req),
    .cf_sub_req(cf_sub_req), .freq_req(freq_req), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .sys_rst(sys_rst), .keep_dom(keep_dom)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [CW-1:0] v);
    rd_addr = a;
    rd_en = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic clear_cause();
    rd_addr = 1'b0;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_por();
    por_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  // Inputs already driven at a negedge; returns latency and pulse length.
  // If inj, freq_req rises 5 cycles into the pulse. Requests drop once the pulse is seen.
  task automatic measure(input bit inj, output int lat, output int len);
    lat = 0;
    len = 0;
    while (!sys_rst && lat < 10) begin @(negedge clk); lat++; end
    wdg_req = 0; cf_main_req = 0; cf_sub_req = 0;
    if (!inj) freq_req = 0;
    while (sys_rst && len < 40) begin
      @(negedge clk);
      len++;
      if (inj && len == 5) freq_req = 1'b1;
      if (inj && len == 10) freq_req = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    chk("R9 sys_rst during por", 32'(sys_rst), 1);
    chk("R9 keep_dom during por", 32'(keep_dom), 0);
    por_n = 1'b1;
    @(negedge clk);
    chk("R9 keep_dom idle", 32'(keep_dom), 0);
    rd(1'b0, v); chk("R8 cause after por", 32'(v), 0);
    rd(1'b1, v); chk("R8 sup after por", 32'(v), 0);
  endtask

  task automatic t_wdg();
    int lat, len;
    logic [CW-1:0] v;
    wdg_req = 1'b1;
    measure(1'b0, lat, len);
    chk("R4 latency", 32'(lat), 3);
    chk("R4 pulse length", 32'(len), LEN);
    chk("R9 keep_dom after pulse", 32'(keep_dom), 0);
    rd(1'b0, v); chk("R1 cause wdg", 32'(v), 32'h20);
    rd(1'b1, v); chk("R1 sup untouched", 32'(v), 0);
  endtask

  task automatic t_keep();
    int seen_mis = 0, seen_hi = 0;
    wdg_req = 1'b1;
    repeat (25) begin
      @(negedge clk);
      if (keep_dom !== sys_rst) seen_mis++;
      if (keep_dom) seen_hi++;
    end
    wdg_req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 keep_dom tracks pulse", 32'(seen_mis), 0);
    chk("R9 keep_dom high cycles", 32'(seen_hi), LEN);
    clear_cause();
  endtask

  task automatic t_main();
    int lat, len;
    logic [CW-1:0] v;
    clear_cause();
    cf_main_req = 1'b1;
    measure(1'b0, lat, len);
    chk("R2 main pulse length", 32'(len), LEN);
    rd(1'b0, v); chk("R2 cause main", 32'(v), 32'h40);
    rd(1'b1, v); chk("R2 sup main", 32'(v), 32'h1);
  endtask

  task automatic t_sub_accum();
    int lat, len;
    logic [CW-1:0] v;
    cf_sub_req = 1'b1;
    measure(1'b0, lat, len);
    rd(1'b1, v); chk("R2 sup sub added", 32'(v), 32'h3);
    rd(1'b0, v); chk("R8 cause kept across pulse", 32'(v), 32'h40);
  endtask

  task automatic t_freq();
    int lat, len;
    logic [CW-1:0] v;
    clear_cause();
    rd(1'b0, v); chk("R7 read clear", 32'(v), 0);
    rd(1'b1, v); chk("R7 sup survives read", 32'(v), 32'h3);
    freq_req = 1'b1;
    measure(1'b0, lat, len);
    rd(1'b0, v); chk("R3 cause freq", 32'(v), 32'h80);
  endtask

  task automatic t_accum_noread();
    int lat, len;
    logic [CW-1:0] v;
    rd_addr = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    rd(1'b0, v); chk("R7 addr1 strobe no clear", 32'(v), 32'h80);
    wdg_req = 1'b1;
    measure(1'b0, lat, len);
    rd(1'b0, v); chk("R8 accumulate", 32'(v), 32'hA0);
    rd(1'b0, v); chk("R7 plain read no clear", 32'(v), 32'hA0);
  endtask

  task automatic t_simul();
    int lat, len;
    logic [CW-1:0] v;
    clear_cause();
    wdg_req = 1'b1; freq_req = 1'b1; cf_main_req = 1'b1;
    measure(1'b0, lat, len);
    chk("R5 simultaneous one pulse", 32'(len), LEN);
    chk("R5 no second pulse", 32'(sys_rst), 0);
    rd(1'b0, v); chk("R5 simultaneous bits", 32'(v), 32'hE0);
  endtask

  task automatic t_no_extend();
    int lat, len;
    logic [CW-1:0] v;
    clear_cause();
    wdg_req = 1'b1;
    measure(1'b1, lat, len);
    chk("R5 pulse not lengthened", 32'(len), LEN);
    chk("R5 no pulse after", 32'(sys_rst), 0);
    rd(1'b0, v); chk("R5 in-pulse request recorded", 32'(v), 32'hA0);
  endtask

  task automatic t_held();
    int hi = 0;
    clear_cause();
    wdg_req = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (sys_rst) hi++;
    end
    chk("R6 held request one pulse", 32'(hi), LEN);
    wdg_req = 1'b0;
    repeat (4) @(negedge clk);
    wdg_req = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 re-rise starts pulse", 32'(sys_rst), 1);
    wdg_req = 1'b0;
    repeat (25) @(negedge clk);
  endtask

  task automatic t_clear_race();
    logic [CW-1:0] v;
    clear_cause();
    wdg_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_addr = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    wdg_req = 1'b0;
    rd(1'b0, v); chk("R7 set wins over clear", 32'(v), 32'h20);
    repeat (25) @(negedge clk);
  endtask

  task automatic t_por_clear();
    logic [CW-1:0] v;
    do_por();
    rd(1'b0, v); chk("R8 por clears cause", 32'(v), 0);
    rd(1'b1, v); chk("R8 por clears sup", 32'(v), 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_wdg();
    t_keep();
    t_main();
    t_sub_accum();
    t_freq();
    t_accum_noread();
    t_simul();
    t_no_extend();
    t_held();
    t_clear_race();
    t_por_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule